// File: doc/BRIEF.md
# Loop Activation Sequencer

This block steers the activation and deactivation of a digital subscriber loop transceiver at the line-termination end. A host issues single-cycle command pulses: power up, power down, activate request, activate continue and deactivate confirm. The line side reports single-bit events: wake-up tone seen, superframe sync found, frame sync lost, line signal present, and the received activity bit. The block answers with a 4-bit status code, a transmit activity bit, a bearer-channel enable, an active-low signal-detect pin and a flag that tells whether the current attempt is a cold or a warm start.

All timeouts count pulses of one prescaled tick input. There are three windows: a long activation limit, which the host can switch off so that an external timer can be used; a medium resynchronisation window; and a short deactivation guard. An optional breakpoint stops the sequence once sync is found, with the transmit activity bit held low, until the host releases it. Every change of the status code is offered on an interrupt output. That output also carries one auxiliary source, and the status code always takes priority over it.

Top module: `line_act_seq`

## Requirements
- R1: After power-on reset (rst_ni low) the block is powered down, the status is DI, tx_act_o, bearer_en_o and seq_warm_o are 0, sd_no is 1 and irq_vld_o is 0.
- R2: Commands are one-cycle pulses and only act in these states: power-up when powered down; activate request when idle; activate continue in the breakpoint hold; deactivate confirm when idle with DI as the current status, which powers the block down. Power-down acts in every state except the deactivation guard. Any other command is ignored.
- R3: seq_warm_o takes the warm-start history flag when an activate request is accepted. The flag is set when full activation is reached. Power-on reset clears it, and so does every fault path (activation timeout, failed resynchronisation, sync loss without line signal). Power-down and deactivate confirm leave it unchanged.
- R4: Only an activate request moves an idle block onward. While activating, superframe sync with the breakpoint off gives status AI, tx_act_o=1 and bearer_en_o=1.
- R5: With the breakpoint on, superframe sync gives status SYNC and keeps tx_act_o at 0. Activate continue then gives AI and tx_act_o=1.
- R6: When the internal timer is enabled and activation has not completed by the T15_TICKS-th tick after the request, status EI is raised on that tick, DI follows one cycle later, and the block returns to idle. With the internal timer disabled, activation never times out.
- R7: Frame sync loss while activated and with a line signal present raises EI and clears bearer_en_o and tx_act_o. Sync regained within T480_TICKS ticks restores AI. Otherwise DI is raised on the T480_TICKS-th tick and the block goes idle. Sync loss without a line signal raises DI at once.
- R8: While activated, a 1-to-0 change of the received activity bit raises EI, and the line stays activated.
- R9: A wake-up tone when powered down gives status LSD and drives sd_no low until power-up. A tone when idle and powered gives status AP.
- R10: Power-down on an activated line clears tx_act_o and bearer_en_o at once. DI is raised on the T40_TICKS-th tick after that, and the block is then powered down.
- R11: Status codes: DI=1, LSD=2, AP=3, AI=4, EI=5, SYNC=6. Every change of the code appears in the same cycle on irq_vld_o with irq_from_stat_o=1 and irq_code_o equal to the new code. An auxiliary request that collides with a status change is held and delivered in the first cycle without a status change, with irq_from_stat_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Prescaled timer tick |
| tmr_int_en_i | input | 1 | Enable for the internal activation timeout |
| bp_en_i | input | 1 | Breakpoint enable |
| cmd_ar_i | input | 1 | Activate request pulse |
| cmd_ac_i | input | 1 | Activate continue pulse |
| cmd_dc_i | input | 1 | Deactivate confirm pulse |
| cmd_pup_i | input | 1 | Power-up pulse |
| cmd_pdn_i | input | 1 | Power-down pulse |
| ev_tone_i | input | 1 | Wake-up tone detected |
| ev_sfsync_i | input | 1 | Superframe sync acquired |
| ev_fsync_lost_i | input | 1 | Frame sync lost pulse |
| sig_present_i | input | 1 | Line signal still present |
| rx_act_i | input | 1 | Received activity bit |
| aux_req_i | input | 1 | Auxiliary interrupt request pulse |
| aux_code_i | input | 4 | Auxiliary interrupt code |
| stat_o | output | 4 | Current status code |
| tx_act_o | output | 1 | Transmit activity bit |
| bearer_en_o | output | 1 | Bearer channels enabled |
| sd_no | output | 1 | Active-low signal-detect pin |
| seq_warm_o | output | 1 | Current attempt is a warm start |
| irq_vld_o | output | 1 | Interrupt entry valid |
| irq_code_o | output | 4 | Interrupt code |
| irq_from_stat_o | output | 1 | Interrupt entry is the status code |

## Verification
The bench builds the block with T15_TICKS=20, T480_TICKS=8 and T40_TICKS=4, and it drives tick_i directly. At these values the activation timeout, the resynchronisation window and the deactivation guard each expire within a few dozen cycles. The exact expiring tick can therefore be checked against the tick just before it, both with the internal timer on and with it off. The small values also let the bench chain cold and warm attempts, and both fault paths, in one run.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [2:0] {
    S_PDN, S_IDLE, S_ACT, S_HOLD, S_ON, S_RESYNC, S_FAIL, S_DEACT
  } lsq_state_e;

  localparam logic [3:0] CODE_DI   = 4'h1;
  localparam logic [3:0] CODE_LSD  = 4'h2;
  localparam logic [3:0] CODE_AP   = 4'h3;
  localparam logic [3:0] CODE_AI   = 4'h4;
  localparam logic [3:0] CODE_EI   = 4'h5;
  localparam logic [3:0] CODE_SYNC = 4'h6;
endpackage

// File: rtl/lsq_timer.sv
module lsq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // zero count means idle; expiry on the tick that drains the last unit
  assign expire_o = tick_i && !load_i && (cnt_q == TW'(1));
endmodule

// File: rtl/lsq_fsm.sv
module lsq_fsm
  import lsq_pkg::*;
#(
  parameter int TW         = 8,
  parameter int T15_TICKS  = 150,
  parameter int T480_TICKS = 48,
  parameter int T40_TICKS  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tmr_int_en_i,
  input  logic          bp_en_i,
  input  logic          cmd_ar_i,
  input  logic          cmd_ac_i,
  input  logic          cmd_dc_i,
  input  logic          cmd_pup_i,
  input  logic          cmd_pdn_i,
  input  logic          ev_tone_i,
  input  logic          ev_sfsync_i,
  input  logic          ev_fsync_lost_i,
  input  logic          sig_present_i,
  input  logic          rx_act_i,
  input  logic          tmr_exp_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output lsq_state_e    state_o,
  output logic [3:0]    stat_o,
  output logic          push_o,
  output logic          tx_act_o,
  output logic          bearer_en_o,
  output logic          sd_no,
  output logic          seq_warm_o
);
  lsq_state_e state_q, state_d;
  logic [3:0] stat_q, stat_d;
  logic push_q, warm_q, warm_d, sd_q, sd_d, seqw_q, seqw_d, rx_act_q;

  always_comb begin
    state_d = state_q;
    stat_d  = stat_q;
    warm_d  = warm_q;
    sd_d    = sd_q;
    seqw_d  = seqw_q;
    unique case (state_q)
      S_PDN: begin
        if (cmd_pup_i) begin
          state_d = S_IDLE;
          sd_d    = 1'b1;
        end else if (ev_tone_i) begin
          stat_d = CODE_LSD;
          sd_d   = 1'b0;
        end
      end
      S_IDLE: begin
        if (cmd_pdn_i) state_d = S_PDN;
        else if (cmd_ar_i) begin
          state_d = S_ACT;
          seqw_d  = warm_q;
        end else if (cmd_dc_i && stat_q == CODE_DI) state_d = S_PDN;
        else if (ev_tone_i) stat_d = CODE_AP;
      end
      S_ACT: begin
        if (cmd_pdn_i) state_d = S_PDN;
        else if (ev_sfsync_i) begin
          if (bp_en_i) begin
            state_d = S_HOLD;
            stat_d  = CODE_SYNC;
          end else begin
            state_d = S_ON;
            stat_d  = CODE_AI;
            warm_d  = 1'b1;
          end
        end else if (tmr_exp_i) begin
          state_d = S_FAIL;
          stat_d  = CODE_EI;
          warm_d  = 1'b0;
        end
      end
      S_HOLD: begin
        if (cmd_pdn_i) state_d = S_PDN;
        else if (cmd_ac_i) begin
          state_d = S_ON;
          stat_d  = CODE_AI;
          warm_d  = 1'b1;
        end else if (tmr_exp_i) begin
          state_d = S_FAIL;
          stat_d  = CODE_EI;
          warm_d  = 1'b0;
        end
      end
      S_ON: begin
        if (cmd_pdn_i) state_d = S_DEACT;
        else if (ev_fsync_lost_i) begin
          if (sig_present_i) begin
            state_d = S_RESYNC;
            stat_d  = CODE_EI;
          end else begin
            state_d = S_IDLE;
            stat_d  = CODE_DI;
            warm_d  = 1'b0;
          end
        end else if (rx_act_q && !rx_act_i) stat_d = CODE_EI;
      end
      S_RESYNC: begin
        if (cmd_pdn_i) state_d = S_PDN;
        else if (ev_sfsync_i) begin
          state_d = S_ON;
          stat_d  = CODE_AI;
        end else if (tmr_exp_i) begin
          state_d = S_IDLE;
          stat_d  = CODE_DI;
          warm_d  = 1'b0;
        end
      end
      S_FAIL: begin
        state_d = S_IDLE;
        stat_d  = CODE_DI;
      end
      S_DEACT: begin
        if (tmr_exp_i) begin
          state_d = S_PDN;
          stat_d  = CODE_DI;
        end
      end
      default: state_d = S_PDN;
    endcase
  end

  // timer reloads only on entry to a timed state; the hold keeps the activation count
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (state_d != state_q) begin
      unique case (state_d)
        S_ACT: begin
          tmr_load_o = 1'b1;
          tmr_val_o  = tmr_int_en_i ? TW'(T15_TICKS) : '0;
        end
        S_RESYNC: begin
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(T480_TICKS);
        end
        S_DEACT: begin
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(T40_TICKS);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_PDN;
      stat_q   <= CODE_DI;
      push_q   <= 1'b0;
      warm_q   <= 1'b0;
      sd_q     <= 1'b1;
      seqw_q   <= 1'b0;
      rx_act_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      stat_q   <= stat_d;
      push_q   <= (stat_d != stat_q);
      warm_q   <= warm_d;
      sd_q     <= sd_d;
      seqw_q   <= seqw_d;
      rx_act_q <= rx_act_i;
    end
  end

  assign state_o     = state_q;
  assign stat_o      = stat_q;
  assign push_o      = push_q;
  assign tx_act_o    = (state_q == S_ON);
  assign bearer_en_o = (state_q == S_ON);
  assign sd_no       = sd_q;
  assign seq_warm_o  = seqw_q;
endmodule

// File: rtl/lsq_irq_arb.sv
module lsq_irq_arb #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [CW-1:0] stat_i,
  input  logic          aux_req_i,
  input  logic [CW-1:0] aux_code_i,
  output logic          irq_vld_o,
  output logic [CW-1:0] irq_code_o,
  output logic          irq_from_stat_o
);
  logic          pend_q;
  logic [CW-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      code_q <= '0;
    end else if (aux_req_i) begin
      pend_q <= 1'b1;
      code_q <= aux_code_i;
    end else if (!push_i) begin
      pend_q <= 1'b0;
    end
  end

  assign irq_vld_o       = push_i | pend_q;
  assign irq_code_o      = push_i ? stat_i : code_q;
  assign irq_from_stat_o = push_i;
endmodule

// File: rtl/line_act_seq.sv
module line_act_seq
  import lsq_pkg::*;
#(
  parameter int T15_TICKS  = 15000,
  parameter int T480_TICKS = 480,
  parameter int T40_TICKS  = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       tmr_int_en_i,
  input  logic       bp_en_i,
  input  logic       cmd_ar_i,
  input  logic       cmd_ac_i,
  input  logic       cmd_dc_i,
  input  logic       cmd_pup_i,
  input  logic       cmd_pdn_i,
  input  logic       ev_tone_i,
  input  logic       ev_sfsync_i,
  input  logic       ev_fsync_lost_i,
  input  logic       sig_present_i,
  input  logic       rx_act_i,
  input  logic       aux_req_i,
  input  logic [3:0] aux_code_i,
  output logic [3:0] stat_o,
  output logic       tx_act_o,
  output logic       bearer_en_o,
  output logic       sd_no,
  output logic       seq_warm_o,
  output logic       irq_vld_o,
  output logic [3:0] irq_code_o,
  output logic       irq_from_stat_o
);
  localparam int TMAX_A = (T15_TICKS > T480_TICKS) ? T15_TICKS : T480_TICKS;
  localparam int TMAX   = (TMAX_A > T40_TICKS) ? TMAX_A : T40_TICKS;
  localparam int TW     = $clog2(TMAX + 1);

  logic          tmr_load, tmr_exp, stat_push;
  logic [TW-1:0] tmr_val;
  lsq_state_e    fsm_state;

  lsq_timer #(.TW(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .load_val_i(tmr_val),
    .tick_i(tick_i), .expire_o(tmr_exp)
  );

  lsq_fsm #(
    .TW(TW), .T15_TICKS(T15_TICKS), .T480_TICKS(T480_TICKS), .T40_TICKS(T40_TICKS)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmr_int_en_i(tmr_int_en_i), .bp_en_i(bp_en_i),
    .cmd_ar_i(cmd_ar_i), .cmd_ac_i(cmd_ac_i), .cmd_dc_i(cmd_dc_i),
    .cmd_pup_i(cmd_pup_i), .cmd_pdn_i(cmd_pdn_i), .ev_tone_i(ev_tone_i),
    .ev_sfsync_i(ev_sfsync_i), .ev_fsync_lost_i(ev_fsync_lost_i),
    .sig_present_i(sig_present_i), .rx_act_i(rx_act_i), .tmr_exp_i(tmr_exp),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .state_o(fsm_state),
    .stat_o(stat_o), .push_o(stat_push), .tx_act_o(tx_act_o),
    .bearer_en_o(bearer_en_o), .sd_no(sd_no), .seq_warm_o(seq_warm_o)
  );

  lsq_irq_arb #(.CW(4)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(stat_push), .stat_i(stat_o),
    .aux_req_i(aux_req_i), .aux_code_i(aux_code_i), .irq_vld_o(irq_vld_o),
    .irq_code_o(irq_code_o), .irq_from_stat_o(irq_from_stat_o)
  );
endmodule

// File: rtl/line_act_seq_chk.sv
module line_act_seq_chk
  import lsq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input lsq_state_e state_i,
  input logic       cmd_ar_i,
  input logic       cmd_dc_i,
  input logic       cmd_pup_i,
  input logic       cmd_pdn_i,
  input logic [3:0] stat_o,
  input logic       tx_act_o,
  input logic       sd_no,
  input logic       irq_vld_o,
  input logic [3:0] irq_code_o,
  input logic       irq_from_stat_o
);
  // R2
  pdn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_PDN && !cmd_pup_i) |=> state_i == S_PDN);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_IDLE && !cmd_ar_i && !cmd_dc_i && !cmd_pdn_i) |=> state_i == S_IDLE);

  // R5
  hold_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_HOLD |-> !tx_act_o);

  // R6
  fail_then_di_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FAIL |=> (stat_o == CODE_DI && state_i == S_IDLE));

  // R9
  sd_only_pdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_no |-> state_i == S_PDN);

  // R11
  stat_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_o) |-> (irq_vld_o && irq_from_stat_o && irq_code_o == stat_o));
endmodule

bind line_act_seq line_act_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(fsm_state), .cmd_ar_i(cmd_ar_i),
  .cmd_dc_i(cmd_dc_i), .cmd_pup_i(cmd_pup_i), .cmd_pdn_i(cmd_pdn_i),
  .stat_o(stat_o), .tx_act_o(tx_act_o), .sd_no(sd_no), .irq_vld_o(irq_vld_o),
  .irq_code_o(irq_code_o), .irq_from_stat_o(irq_from_stat_o)
);

// File: tb/line_act_seq_tb_top.sv
`timescale 1ns/1ps
module line_act_seq_tb_top;
  localparam int T15  = 20;
  localparam int T480 = 8;
  localparam int T40  = 4;
  localparam int NV   = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 0, tmr_en = 1, bp = 0;
  logic ar = 0, ac = 0, dc = 0, pup = 0, pdn = 0;
  logic tone = 0, sfs = 0, flost = 0, sigp = 0, rxa = 0;
  logic aux_req = 0;
  logic [3:0] aux_code = '0;
  logic [3:0] stat, irq_code;
  logic tx_act, bearer, sdn, sw, irq_vld, irq_fs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  line_act_seq #(.T15_TICKS(T15), .T480_TICKS(T480), .T40_TICKS(T40)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .tmr_int_en_i(tmr_en), .bp_en_i(bp),
    .cmd_ar_i(ar), .cmd_ac_i(ac), .cmd_dc_i(dc), .cmd_pup_i(pup), .cmd_pdn_i(pdn),
    .ev_tone_i(tone), .ev_sfsync_i(sfs), .ev_fsync_lost_i(flost),
    .sig_present_i(sigp), .rx_act_i(rxa), .aux_req_i(aux_req), .aux_code_i(aux_code),
    .stat_o(stat), .tx_act_o(tx_act), .bearer_en_o(bearer), .sd_no(sdn),
    .seq_warm_o(sw), .irq_vld_o(irq_vld), .irq_code_o(irq_code),
    .irq_from_stat_o(irq_fs)
  );

  // [18:14] {ar,ac,dc,pup,pdn} [13:7] {tone,sfs,flost,sigp,rxa,bp,tick}
  // [6:3] expected status [2:0] expected {tx_act,bearer,seq_warm}
  localparam logic [18:0] VEC [NV] = '{
    {5'b00000, 7'b1000000, 4'h2, 3'b000},  // R9 tone while powered down
    {5'b00010, 7'b0000000, 4'h2, 3'b000},  // R2 power up
    {5'b00000, 7'b1000000, 4'h3, 3'b000},  // R9 tone while idle
    {5'b01000, 7'b0000000, 4'h3, 3'b000},  // R2 continue ignored in idle
    {5'b10000, 7'b0000000, 4'h3, 3'b000},  // R3 cold start
    {5'b00000, 7'b0100000, 4'h4, 3'b110},  // R4 sync -> activated
    {5'b00000, 7'b0000100, 4'h4, 3'b110},  // R8 rx act high
    {5'b00000, 7'b0000000, 4'h5, 3'b110},  // R8 rx act falls
    {5'b00000, 7'b0011000, 4'h5, 3'b000},  // R7 sync lost, signal present
    {5'b00000, 7'b0100000, 4'h4, 3'b110},  // R7 resync
    {5'b00001, 7'b0000000, 4'h4, 3'b000},  // R10 power down from active
    {5'b00000, 7'b0000001, 4'h4, 3'b000},  // R10
    {5'b00000, 7'b0000001, 4'h4, 3'b000},  // R10
    {5'b00000, 7'b0000001, 4'h4, 3'b000},  // R10
    {5'b00000, 7'b0000001, 4'h1, 3'b000},  // R10 guard expiry -> DI
    {5'b00010, 7'b0000000, 4'h1, 3'b000},  // R2 power up
    {5'b10000, 7'b0000000, 4'h1, 3'b001},  // R3 warm start
    {5'b00000, 7'b0100010, 4'h6, 3'b001},  // R5 breakpoint hold
    {5'b01000, 7'b0000010, 4'h4, 3'b111},  // R5 released
    {5'b00000, 7'b0010000, 4'h1, 3'b001}   // R7 sync lost, no signal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    ar = 0; ac = 0; dc = 0; pup = 0; pdn = 0;
    tone = 0; sfs = 0; flost = 0; tick = 0; aux_req = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1;
      step();
      tick = 0;
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 stat", stat, 4'h1);
    chk("R1 tx", tx_act, 0);
    chk("R1 bearer", bearer, 0);
    chk("R1 sd", sdn, 1);
    chk("R1 warm", sw, 0);
    chk("R1 irq", irq_vld, 0);
    rst_ni = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      {ar, ac, dc, pup, pdn} = VEC[i][18:14];
      {tone, sfs, flost, sigp, rxa, bp, tick} = VEC[i][13:7];
      step();
      chk($sformatf("R11 vec%0d stat", i), stat, VEC[i][6:3]);
      chk($sformatf("R4 vec%0d tx", i), tx_act, VEC[i][2]);
      chk($sformatf("R7 vec%0d bearer", i), bearer, VEC[i][1]);
      chk($sformatf("R3 vec%0d warm", i), sw, VEC[i][0]);
      clr();
    end
    bp = 0; sigp = 0; rxa = 0;

    // R2 deactivate confirm with DI current -> powered down; R9 pin low
    dc = 1; step(); clr();
    tone = 1; step(); clr();
    chk("R9 stat LSD", stat, 4'h2);
    chk("R9 sd low", sdn, 0);
    chk("R11 irq LSD", irq_code, 4'h2);
    pup = 1; step(); clr();
    chk("R9 sd released", sdn, 1);

    // R6 activation timeout, cold start after fault (R3)
    ar = 1; step(); clr();
    chk("R3 cold after fault", sw, 0);
    ticks(T15 - 1);
    chk("R6 before expiry", stat, 4'h2);
    ticks(1);
    chk("R6 EI on expiry", stat, 4'h5);
    chk("R11 irq EI", irq_vld & irq_fs, 1);
    step();
    chk("R6 DI after EI", stat, 4'h1);
    sfs = 1; step(); clr();
    chk("R4 idle ignores sync", stat, 4'h1);

    // R6 internal timer disabled
    tmr_en = 0;
    ar = 1; step(); clr();
    ticks(T15 + 10);
    chk("R6 no timeout when disabled", stat, 4'h1);
    sfs = 1; step(); clr();
    chk("R6 completes late", stat, 4'h4);
    tmr_en = 1;

    // R7 resynchronisation timeout clears history (R3)
    sigp = 1; flost = 1; step(); clr();
    chk("R7 EI", stat, 4'h5);
    chk("R7 bearer off", bearer, 0);
    ticks(T480 - 1);
    chk("R7 before window end", stat, 4'h5);
    ticks(1);
    chk("R7 DI on window end", stat, 4'h1);
    sigp = 0;
    ar = 1; step(); clr();
    chk("R3 cleared by resync fail", sw, 0);
    sfs = 1; step(); clr();
    chk("R4 activated", tx_act, 1);

    // R10 + R3 power down keeps history
    pdn = 1; step(); clr();
    chk("R10 tx off at once", tx_act, 0);
    ticks(T40 - 1);
    chk("R10 before guard", stat, 4'h4);
    ticks(1);
    chk("R10 DI after guard", stat, 4'h1);
    pup = 1; step(); clr();
    ar = 1; step(); clr();
    chk("R3 warm kept over power down", sw, 1);

    // R11 priority of status over auxiliary request
    sfs = 1; aux_req = 1; aux_code = 4'h9; step(); clr();
    chk("R11 status first code", irq_code, 4'h4);
    chk("R11 status first src", irq_fs, 1);
    step();
    chk("R11 aux next code", irq_code, 4'h9);
    chk("R11 aux next src", {irq_vld, irq_fs}, 2'b10);
    step();
    chk("R11 idle after aux", irq_vld, 0);
    aux_req = 1; aux_code = 4'hA; step(); clr();
    chk("R11 aux alone", {irq_vld, irq_fs, irq_code}, {2'b10, 4'hA});

    done = 1;
    report();
  end
endmodule